// File: doc/BRIEF.md
# Byte-Wide Atomic Result Register Reader

This block sits between an 8-bit bus master and four 16-bit result registers that a converter engine keeps updating. Because the master can move only one byte per access, a 16-bit value could change between the two halves of a read and come back torn. To prevent this, a read of a register's upper byte does two things. It returns that byte, and in the same access it copies the same register's lower byte into a single shared hold latch. A later read of the lower-byte address returns the held copy, not the live register.

Software reads the upper byte first and the lower byte second, and it always gets a coherent pair. Reading only the upper byte is allowed. A lower-byte read with no upper-byte read before it gets whatever the latch last captured. Read data is registered and comes back one clock after the strobe, with a one-cycle valid flag.

A small read-phase state machine sequences each access. It has three states: `PH_IDLE` (no read last cycle), `PH_UPPER` (an upper-byte read is being answered) and `PH_LOWER` (a lower-byte read is being answered). The state moves as follows:
- From any state, a strobe at an even address goes to `PH_UPPER`.
- From any state, a strobe at an odd address goes to `PH_LOWER`.
- From any state, a cycle with no strobe goes to `PH_IDLE`.

Top module: `snap_byte_reader`

## Requirements
- R1: After reset, `rd_valid` is 0 and `rd_data` is 0x00. All four result registers and the hold latch are 0, so a lower-byte read right after reset returns 0x00.
- R2: A strobe at an even address returns bits [15:8] of the selected register on `rd_data` one clock later, with `rd_valid` high in that cycle.
- R3: A strobe at an even address copies bits [7:0] of the same register into the hold latch.
- R4: A strobe at an odd address returns the hold latch contents, even if the register's live lower byte has changed since the latch was loaded.
- R5: A lower-byte read with no upper-byte read before it returns the latch's last value, which may come from a different register.
- R6: The latch changes only on an upper-byte read. Lower-byte reads, idle cycles and converter writes leave it unchanged, so repeated lower-byte reads return the same byte.
- R7: When a converter write and an upper-byte read hit the same register in the same cycle, both the returned byte and the latch reflect the value from before the write. Later reads see the new value.
- R8: Address bits [2:1] select the register index 0..3. Address bit 0 selects the half: 0 means the upper byte and 1 means the lower byte.
- R9: `rd_valid` is high for exactly the cycle after each strobe. With no strobe, `rd_valid` is 0 and `rd_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe from the bus master |
| rd_addr | input | 3 | Read address: index in [2:1], half in [0] |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | Read data valid, one clock after strobe |
| wr_en | input | 1 | Converter-side result write enable |
| wr_idx | input | 2 | Result register written by the converter |
| wr_val | input | 16 | Result value written by the converter |

## Verification
The bench checks several hazards, each of which a faulty design would show differently:
- It rewrites a register between its upper and lower reads. A design that returns the live low byte would give the new value instead of the snapshot.
- It reads a low half after an upper read of a different register. This catches latch loading on the wrong index, or one latch per register.
- It collides a converter write with an upper read of the same register. A design with write-through forwarding would return or latch the new value.
- It issues back-to-back and repeated lower reads, followed by idle cycles. These catch a latch that is disturbed by low reads, and a valid flag that stays high or data that does not hold.

// File: rtl/snap_rd_pkg.sv
package snap_rd_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_UPPER = 2'd1,
        PH_LOWER = 2'd2
    } rd_phase_e;
endpackage

// File: rtl/snap_result_bank.sv
module snap_result_bank #(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [REG_W-1:0]               wr_val,
    output logic [NUM_REGS-1:0][REG_W-1:0] words
);
    // One register per result slot; converter writes replace the whole word.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                words[g] <= wr_val;
            end
        end
    end
endmodule

// File: rtl/snap_hold_latch.sv
module snap_hold_latch #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end
endmodule

// File: rtl/snap_read_fsm.sv
module snap_read_fsm
    import snap_rd_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rd_lower,
    input  logic [BYTE_W-1:0] upper_byte,
    input  logic [BYTE_W-1:0] held_byte,
    output logic              load_hold,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid
);
    rd_phase_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            PH_IDLE, PH_UPPER, PH_LOWER: begin
                if (!rd_en)        state_d = PH_IDLE;
                else if (rd_lower) state_d = PH_LOWER;
                else               state_d = PH_UPPER;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            unique case (state_d)
                PH_UPPER: rd_data <= upper_byte;
                PH_LOWER: rd_data <= held_byte;
                default:  rd_data <= rd_data;
            endcase
        end
    end

    assign rd_valid  = (state_q != PH_IDLE);
    assign load_hold = (state_d == PH_UPPER);
endmodule

// File: rtl/snap_byte_reader.sv
module snap_byte_reader #(
    parameter int NUM_REGS = 4,
    parameter int BYTE_W   = 8,
    localparam int REG_W   = 2 * BYTE_W,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int ADDR_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [REG_W-1:0]  wr_val
);
    logic [NUM_REGS-1:0][REG_W-1:0] bank_words;
    logic [IDX_W-1:0]               sel_idx;
    logic [REG_W-1:0]               sel_word;
    logic [BYTE_W-1:0]              hold_q;
    logic                           load_hold;

    snap_result_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_val(wr_val), .words(bank_words)
    );

    // even offset = upper half, odd offset = lower half
    assign sel_idx  = rd_addr[ADDR_W-1:1];
    assign sel_word = bank_words[sel_idx];

    snap_hold_latch #(.BYTE_W(BYTE_W)) hold_i (
        .clk(clk), .rst_n(rst_n), .load(load_hold),
        .din(sel_word[BYTE_W-1:0]), .q(hold_q)
    );

    snap_read_fsm #(.BYTE_W(BYTE_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_lower(rd_addr[0]),
        .upper_byte(sel_word[REG_W-1:BYTE_W]), .held_byte(hold_q),
        .load_hold(load_hold), .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: rtl/snap_byte_reader_chk.sv
module snap_byte_reader_chk #(
    parameter int NUM_REGS = 4,
    parameter int BYTE_W   = 8,
    localparam int REG_W   = 2 * BYTE_W,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int ADDR_W  = IDX_W + 1
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           rd_en,
    input logic [ADDR_W-1:0]              rd_addr,
    input logic [BYTE_W-1:0]              rd_data,
    input logic                           rd_valid,
    input logic [NUM_REGS-1:0][REG_W-1:0] words,
    input logic [BYTE_W-1:0]              hold_q
);
    logic [REG_W-1:0] pick;
    logic             hi_rd, lo_rd;
    assign pick  = words[rd_addr[ADDR_W-1:1]];
    assign hi_rd = rd_en && !rd_addr[0];
    assign lo_rd = rd_en &&  rd_addr[0];

    // R2
    upper_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_rd |=> (rd_valid && rd_data == $past(pick[REG_W-1:BYTE_W])));
    // R3
    hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_rd |=> (hold_q == $past(pick[BYTE_W-1:0])));
    // R4
    lower_from_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rd |=> (rd_valid && rd_data == $past(hold_q)));
    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_rd |=> $stable(hold_q));
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && $stable(rd_data)));
endmodule

bind snap_byte_reader snap_byte_reader_chk #(.NUM_REGS(NUM_REGS), .BYTE_W(BYTE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .words(bank_words), .hold_q(hold_q)
);

// File: tb/snap_byte_reader_tb_top.sv
module snap_byte_reader_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        rd_en = 0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        wr_en = 0;
    logic [1:0]  wr_idx = '0;
    logic [15:0] wr_val = '0;

    always #5 clk = ~clk;

    snap_byte_reader dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val)
    );

    typedef struct { logic [7:0] val; string tag; } exp_t;
    exp_t        sb_q[$];
    logic [15:0] m_regs [4];
    logic [7:0]  m_hold;
    logic [7:0]  last_data;
    int          n_run = 0, n_fail = 0;
    bit          done = 0;

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, expectation from the model taken before the write
    task automatic step(input bit rd, input logic [2:0] a, input bit wr,
                        input logic [1:0] wi, input logic [15:0] wv, input string tag);
        exp_t e;
        @(negedge clk);
        if (rd) begin
            e.tag = tag;
            if (!a[0]) begin
                e.val  = m_regs[a[2:1]][15:8];
                m_hold = m_regs[a[2:1]][7:0];
            end else begin
                e.val = m_hold;
            end
            sb_q.push_back(e);
            last_data = e.val;
        end
        if (wr) m_regs[wi] = wv;
        rd_en = rd; rd_addr = a; wr_en = wr; wr_idx = wi; wr_val = wv;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 3'd0, 0, 2'd0, 16'h0, "");
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (sb_q.size() == 0) begin
                check(0, "R9 unexpected valid", {8'h0, rd_data}, 16'h0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(rd_data == e.val, e.tag, {8'h0, rd_data}, {8'h0, e.val});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_regs[i] = '0;
        m_hold = '0; last_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check(rd_valid == 0, "R1 valid after reset", {15'h0, rd_valid}, 16'h0);
        check(rd_data == 8'h00, "R1 data after reset", {8'h0, rd_data}, 16'h0);
        step(1, 3'd1, 0, 2'd0, 16'h0, "R1 low read after reset");
        step(1, 3'd4, 0, 2'd0, 16'h0, "R1 reg2 high after reset");
        // load results
        step(0, 3'd0, 1, 2'd0, 16'hAA40, "");
        step(0, 3'd0, 1, 2'd1, 16'h1234, "");
        step(0, 3'd0, 1, 2'd2, 16'hBEEF, "");
        step(0, 3'd0, 1, 2'd3, 16'h0F0F, "");
        // R2 R3 R8: back-to-back pairs on each register
        for (int r = 0; r < 4; r++) begin
            step(1, {r[1:0], 1'b0}, 0, 2'd0, 16'h0, "R2 R8 upper byte");
            step(1, {r[1:0], 1'b1}, 0, 2'd0, 16'h0, "R3 R8 held lower byte");
        end
        // R4: register changes between halves
        step(1, 3'd4, 0, 2'd0, 16'h0, "R4 upper before change");
        step(0, 3'd0, 1, 2'd2, 16'h5566, "");
        step(1, 3'd5, 0, 2'd0, 16'h0, "R4 snapshot not live");
        // R5: lower read of another register after upper read of reg1
        step(1, 3'd2, 0, 2'd0, 16'h0, "R5 upper reg1");
        step(1, 3'd1, 0, 2'd0, 16'h0, "R5 stale cross-register low");
        // R6: upper only, idle, writes, repeated lower reads
        step(1, 3'd0, 0, 2'd0, 16'h0, "R6 upper only");
        idle(2);
        step(0, 3'd0, 1, 2'd0, 16'h0001, "");
        step(1, 3'd7, 0, 2'd0, 16'h0, "R6 low after idle");
        step(1, 3'd3, 0, 2'd0, 16'h0, "R6 repeated low");
        step(1, 3'd5, 0, 2'd0, 16'h0, "R6 repeated low again");
        // R7: collision of write and upper read
        step(1, 3'd2, 1, 2'd1, 16'hABCD, "R7 collision old upper");
        step(1, 3'd3, 0, 2'd0, 16'h0, "R7 collision old lower");
        step(1, 3'd2, 0, 2'd0, 16'h0, "R7 new upper");
        step(1, 3'd3, 0, 2'd0, 16'h0, "R7 new lower");
        // R9: idle holds data, valid low
        idle(1);
        @(negedge clk);
        check(rd_valid == 0, "R9 valid low when idle", {15'h0, rd_valid}, 16'h0);
        check(rd_data == last_data, "R9 data holds when idle", {8'h0, rd_data}, {8'h0, last_data});
        idle(2);
        check(sb_q.size() == 0, "R9 all reads answered", 16'(sb_q.size()), 16'h0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule